// File: doc/BRIEF.md
# Offset raster line numbering unit

This unit turns the raw vertical count from the video timing into the line number that the display coprocessor, the line-match interrupt and the readable current-line register all see. A programmable 8-bit offset is added to the raw count, and the sum wraps at the frame height. Reported line 0 therefore stays at the first pixel row of the tile and sprite layers. With a non-zero offset N, the main bitmap layer's pixel row 0 shows up as reported line N. A coprocessor wait for line 0 is then met while the beam is still in the top border.

Software writes the offset through a small register port and can read it back at any time. A written value is held pending. It moves into the active offset only when the bitmap layer reaches its pixel row 0, which the timing marks with the frame-start strobe on raw line 0. A change can therefore take up to a full frame to appear. The line whose cycle carries the frame-start strobe already uses the new offset.

The line number and the interrupt pulse are registered. Both reflect the inputs of the previous clock cycle.

Top module: `raster_line_offset`

## Requirements
- R1: After reset the pending and active offsets are 0, `ofs_rd_data` is 0, `line_irq` is 0, and `line_num` equals the raw count sampled one cycle earlier.
- R2: One cycle after any input cycle, `line_num` equals (raw_line + effective offset) mod FRAME_LINES. The effective offset is the pending offset in a cycle where `frame_start` is 1, and the active offset in any other cycle.
- R3: One cycle after a write (`ofs_wr_en` = 1), `ofs_rd_data` returns the written value, even while that value is still pending.
- R4: A written offset does not change `line_num` until the next `frame_start`. From that cycle on, raw line 0 reports the new offset N.
- R5: If several writes occur between two frame starts, only the last one is applied.
- R6: Sums of FRAME_LINES or more wrap. For example, with FRAME_LINES = 312 and offset 255, raw line 100 reports line 43.
- R7: `line_irq` is 1 for exactly one cycle, one cycle after an input cycle in which `line_start` = 1, `irq_en` = 1 and the reported line equals `irq_target`.
- R8: `line_irq` stays 0 when `irq_en` is 0, when `line_start` is 0, or when the reported line differs from the target.
- R9: A write in the same cycle as `frame_start` goes into the pending offset only. That frame applies the previous pending value, and the new value is applied at the following frame start.
- R10: With offset N > 0, reported line 0 is reached at raw line FRAME_LINES − N, which lies in the border before the bitmap's first row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_line | input | LINE_W | Raw vertical count from the video timing, below FRAME_LINES |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| frame_start | input | 1 | One-cycle strobe on raw line 0, at the bitmap layer's pixel row 0 |
| ofs_wr_en | input | 1 | Offset register write strobe |
| ofs_wr_data | input | OFS_W | Offset value to write |
| ofs_rd_data | output | OFS_W | Last written offset (read-back) |
| irq_en | input | 1 | Line interrupt enable |
| irq_target | input | LINE_W | Reported line on which the interrupt fires |
| line_num | output | LINE_W | Offset line number for the coprocessor and the readout |
| line_irq | output | 1 | One-cycle line-match interrupt pulse |

## Verification
The bench builds the unit with its default parameters: a 312-line frame, a 9-bit line number and an 8-bit offset. With those values, offsets up to 255 push sums past the frame height, so wrap-around at raw lines near 311 and at large offsets falls within reach. The directed scenarios step the raw count by hand rather than running whole frames. This makes it possible to place writes just before, during and after the frame-start cycle and to watch the pending-to-active hand-over on the exact line where it happens.

// File: rtl/rlo_pkg.sv
package rlo_pkg;
  // Adds an offset to a raw line count and wraps once at the frame height.
  // Both operands are below the frame height here, so one subtraction suffices.
  function automatic int unsigned wrap_line(input int unsigned raw,
                                            input int unsigned ofs,
                                            input int unsigned frame);
    int unsigned s;
    s = raw + ofs;
    if (s >= frame) s = s - frame;
    return s;
  endfunction
endpackage

// File: rtl/rlo_offset_regs.sv
module rlo_offset_regs #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_data,
  input  logic             apply,
  output logic [OFS_W-1:0] pend_q,
  output logic [OFS_W-1:0] act_q,
  output logic [OFS_W-1:0] eff_ofs
);
  // Pending holds the software value; active moves only at bitmap row 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_en) pend_q <= wr_data;
      if (apply) act_q  <= pend_q;
    end
  end

  // The row-0 line itself already uses the value being transferred.
  always_comb eff_ofs = apply ? pend_q : act_q;
endmodule

// File: rtl/rlo_line_calc.sv
module rlo_line_calc #(
  parameter int LINE_W      = 9,
  parameter int OFS_W       = 8,
  parameter int FRAME_LINES = 312
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] raw_line,
  input  logic [OFS_W-1:0]  eff_ofs,
  output logic [LINE_W-1:0] line_comb,
  output logic [LINE_W-1:0] line_q
);
  import rlo_pkg::*;

  always_comb
    line_comb = LINE_W'(wrap_line(int'(raw_line), int'(eff_ofs), FRAME_LINES));

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= line_comb;
  end
endmodule

// File: rtl/rlo_line_irq.sv
module rlo_line_irq #(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              irq_en,
  input  logic [LINE_W-1:0] target,
  input  logic [LINE_W-1:0] line_comb,
  output logic              irq_q
);
  logic hit;
  always_comb hit = line_start && irq_en && (line_comb == target);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= hit;
  end
endmodule

// File: rtl/raster_line_offset.sv
module raster_line_offset #(
  parameter int LINE_W      = 9,
  parameter int OFS_W       = 8,
  parameter int FRAME_LINES = 312
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] raw_line,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic              ofs_wr_en,
  input  logic [OFS_W-1:0]  ofs_wr_data,
  output logic [OFS_W-1:0]  ofs_rd_data,
  input  logic              irq_en,
  input  logic [LINE_W-1:0] irq_target,
  output logic [LINE_W-1:0] line_num,
  output logic              line_irq
);
  logic [OFS_W-1:0]  pend_ofs;
  logic [OFS_W-1:0]  act_ofs;
  logic [OFS_W-1:0]  eff_ofs;
  logic [LINE_W-1:0] line_comb;

  rlo_offset_regs #(.OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(ofs_wr_en), .wr_data(ofs_wr_data),
    .apply(frame_start),
    .pend_q(pend_ofs), .act_q(act_ofs), .eff_ofs(eff_ofs)
  );

  rlo_line_calc #(.LINE_W(LINE_W), .OFS_W(OFS_W), .FRAME_LINES(FRAME_LINES)) u_calc (
    .clk(clk), .rst(rst),
    .raw_line(raw_line), .eff_ofs(eff_ofs),
    .line_comb(line_comb), .line_q(line_num)
  );

  rlo_line_irq #(.LINE_W(LINE_W)) u_irq (
    .clk(clk), .rst(rst),
    .line_start(line_start), .irq_en(irq_en), .target(irq_target),
    .line_comb(line_comb), .irq_q(line_irq)
  );

  assign ofs_rd_data = pend_ofs;
endmodule

// File: rtl/rlo_checker.sv
module rlo_checker #(
  parameter int LINE_W      = 9,
  parameter int OFS_W       = 8,
  parameter int FRAME_LINES = 312
) (
  input logic              clk,
  input logic              rst,
  input logic              line_start,
  input logic              frame_start,
  input logic              ofs_wr_en,
  input logic [OFS_W-1:0]  ofs_wr_data,
  input logic [OFS_W-1:0]  ofs_rd_data,
  input logic              irq_en,
  input logic [LINE_W-1:0] irq_target,
  input logic [LINE_W-1:0] line_num,
  input logic              line_irq,
  input logic [OFS_W-1:0]  act_ofs
);
  a_r2_line_range: assert property (@(posedge clk) disable iff (rst)
    int'(line_num) < FRAME_LINES);

  a_r3_readback: assert property (@(posedge clk) disable iff (rst)
    $past(ofs_wr_en) |-> ofs_rd_data == $past(ofs_wr_data));

  a_r4_active_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_start) |-> $stable(act_ofs));

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
    line_irq |-> ($past(line_start) && $past(irq_en) && line_num == $past(irq_target)));

  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !$past(line_start) |-> !line_irq);
endmodule

bind raster_line_offset rlo_checker #(
  .LINE_W(LINE_W), .OFS_W(OFS_W), .FRAME_LINES(FRAME_LINES)
) u_chk (
  .clk(clk), .rst(rst), .line_start(line_start), .frame_start(frame_start),
  .ofs_wr_en(ofs_wr_en), .ofs_wr_data(ofs_wr_data), .ofs_rd_data(ofs_rd_data),
  .irq_en(irq_en), .irq_target(irq_target), .line_num(line_num),
  .line_irq(line_irq), .act_ofs(act_ofs)
);

// File: tb/raster_line_offset_bench.sv
module raster_line_offset_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 9;
  localparam int OW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] raw_line = '0;
  logic          line_start = 1'b0;
  logic          frame_start = 1'b0;
  logic          ofs_wr_en = 1'b0;
  logic [OW-1:0] ofs_wr_data = '0;
  logic [OW-1:0] ofs_rd_data;
  logic          irq_en = 1'b0;
  logic [LW-1:0] irq_target = '0;
  logic [LW-1:0] line_num;
  logic          line_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_line_offset u_raster_line_offset (
    .clk(clk), .rst(rst), .raw_line(raw_line), .line_start(line_start),
    .frame_start(frame_start), .ofs_wr_en(ofs_wr_en), .ofs_wr_data(ofs_wr_data),
    .ofs_rd_data(ofs_rd_data), .irq_en(irq_en), .irq_target(irq_target),
    .line_num(line_num), .line_irq(line_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one input cycle at a falling edge; outputs are valid at the next one.
  task automatic tick(input int raw, input bit ls, input bit fs,
                      input bit we, input int wd);
    raw_line    = LW'(raw);
    line_start  = ls;
    frame_start = fs;
    ofs_wr_en   = we;
    ofs_wr_data = OW'(wd);
    @(negedge clk);
    line_start  = 1'b0;
    frame_start = 1'b0;
    ofs_wr_en   = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    tick(5, 1'b1, 1'b0, 1'b0, 0);
    chk("R1 line after reset", line_num, 5);
    chk("R1 readback after reset", ofs_rd_data, 0);
    chk("R1 irq after reset", line_irq, 0);
  endtask

  task automatic t_apply();
    tick(9, 1'b0, 1'b0, 1'b1, 32);
    chk("R3 readback pending", ofs_rd_data, 32);
    tick(10, 1'b1, 1'b0, 1'b0, 0);
    chk("R4 pending not applied", line_num, 10);
    tick(0, 1'b1, 1'b1, 1'b0, 0);
    chk("R4 row0 reports offset", line_num, 32);
    tick(1, 1'b1, 1'b0, 1'b0, 0);
    chk("R2 line after apply", line_num, 33);
    tick(280, 1'b1, 1'b0, 1'b0, 0);
    chk("R10 line 0 in border", line_num, 0);
    tick(311, 1'b1, 1'b0, 1'b0, 0);
    chk("R6 wrap last line", line_num, 31);
  endtask

  task automatic t_multi();
    tick(2, 1'b0, 1'b0, 1'b1, 7);
    tick(2, 1'b0, 1'b0, 1'b1, 200);
    chk("R3 readback last", ofs_rd_data, 200);
    tick(3, 1'b1, 1'b0, 1'b0, 0);
    chk("R4 old offset kept", line_num, 35);
    tick(0, 1'b1, 1'b1, 1'b0, 0);
    chk("R5 last write applied", line_num, 200);
    tick(150, 1'b1, 1'b0, 1'b0, 0);
    chk("R6 wrap 150+200", line_num, 38);
    tick(2, 1'b0, 1'b0, 1'b1, 255);
    tick(0, 1'b1, 1'b1, 1'b0, 0);
    tick(100, 1'b1, 1'b0, 1'b0, 0);
    chk("R6 wrap 100+255", line_num, 43);
  endtask

  task automatic t_same_cycle();
    tick(2, 1'b0, 1'b0, 1'b1, 200);
    tick(0, 1'b1, 1'b1, 1'b1, 9);
    chk("R9 frame applies previous", line_num, 200);
    chk("R9 readback new", ofs_rd_data, 9);
    tick(5, 1'b1, 1'b0, 1'b0, 0);
    chk("R9 still previous", line_num, 205);
    tick(0, 1'b1, 1'b1, 1'b0, 0);
    chk("R9 next frame applies", line_num, 9);
  endtask

  task automatic t_irq();
    irq_target = 9'd20;
    irq_en = 1'b1;
    tick(11, 1'b1, 1'b0, 1'b0, 0);
    chk("R7 irq on match", line_irq, 1);
    chk("R7 line at irq", line_num, 20);
    tick(11, 1'b0, 1'b0, 1'b0, 0);
    chk("R7 irq one cycle", line_irq, 0);
    tick(12, 1'b1, 1'b0, 1'b0, 0);
    chk("R8 no irq mismatch", line_irq, 0);
    irq_en = 1'b0;
    tick(11, 1'b1, 1'b0, 1'b0, 0);
    chk("R8 no irq disabled", line_irq, 0);
    irq_en = 1'b1;
    irq_target = 9'd0;
    tick(303, 1'b1, 1'b0, 1'b0, 0);
    chk("R10 irq line 0 in border", line_irq, 1);
    irq_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_apply();
    t_multi();
    t_same_cycle();
    t_irq();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule